// File: doc/BRIEF.md
# Immediate-Operand Integer Execute Unit

This unit performs the execute step for data-processing instructions whose second operand is an immediate. It is purely combinational. It has two paths. The first adds a 12-bit immediate to a source register value, or subtracts it. The immediate can be moved up by 12 bit positions first, and the add or subtract can update the four condition flags (negative, zero, carry, overflow). The second path builds a 64-bit or 32-bit value from a 16-bit immediate placed in one of four 16-bit lanes. That lane is either surrounded by zeros, inverted as a whole, or merged into the current destination value.

The surrounding pipeline supplies the decoded operation, the operand width, the source and current destination values, and the incoming flags. It takes back the result, a write enable for the register file and the flags to keep. Register storage, decode and memory traffic sit outside this block.

Top module: `exu_imm_exec`

## Requirements
- R1: `op_sel` codes are 0 ADD, 1 ADDS, 2 SUB, 3 SUBS, 4 MOVN, 5 MOVZ, 6 MOVK and 7 reserved. `wide_mode`=1 selects 64-bit operation and 0 selects 32-bit operation. A legal operation drives `wr_en`=1 and `illegal`=0.
- R2: When `arith_sh`=1, the 12-bit arithmetic immediate is moved left by 12 bits before the add or subtract.
- R3: The flag vector is bit3 N, bit2 Z, bit1 C, bit0 V. For every code other than ADDS and SUBS, `flag_out` equals `flag_in`.
- R4: For ADDS and SUBS, N is the top bit of the result at the selected width. Z is 1 exactly when the truncated result is zero.
- R5: For SUBS, C is 1 when the unsigned source is at least the immediate. V is 1 when the operand signs differ and the result sign equals the immediate's sign.
- R6: For ADDS, C is the unsigned carry out of the selected width. V is 1 when both operands share a sign and the result sign differs from it.
- R7: In 32-bit mode only the low 32 bits of the source and destination inputs are used, and `result[63:32]` is zero.
- R8: MOVZ writes the 16-bit immediate shifted left by `mov_field`×16, with all other bits zero. MOVN writes the bitwise inverse of that value, truncated to the width.
- R9: MOVK replaces only lane `mov_field` of `dst_cur` with the immediate and keeps every other bit at the selected width.
- R10: A move with `mov_field` of 2 or 3 in 32-bit mode drives `illegal`=1, `wr_en`=0 and `result`=0, and leaves the flags unchanged.
- R11: The reserved code 7 drives `illegal`=1, `wr_en`=0 and `result`=0, and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code |
| wide_mode | input | 1 | 1 = 64-bit, 0 = 32-bit |
| src_val | input | 64 | Source register value for add/subtract |
| dst_cur | input | 64 | Current destination value, used by MOVK |
| arith_imm | input | 12 | Arithmetic immediate |
| arith_sh | input | 1 | Move the arithmetic immediate up 12 bits |
| mov_imm | input | 16 | Wide-move immediate |
| mov_field | input | 2 | Lane select for the wide move |
| flag_in | input | 4 | Current NZCV flags |
| result | output | 64 | Value to write back |
| wr_en | output | 1 | Write-back enable |
| flag_out | output | 4 | NZCV flags after the operation |
| illegal | output | 1 | Operation cannot be performed |

## Verification
The bench targets carry and overflow where they split apart:
- a 32-bit add that wraps to zero, which a design taking the carry from bit 64 would report without carry;
- signed overflow at both widths, both for an add and for a subtract;
- an equal subtract, where a borrow-style carry would wrongly come out clear.

Garbage in the upper half of 32-bit inputs shows whether truncation is applied. Moves into the highest lane, and into lanes 2 and 3 at 32 bits, show a misplaced field, a MOVK that disturbs its neighbours, or a move that writes when it must be refused. Plain ADD and SUB run with all flags set, which exposes a design that updates flags for every arithmetic operation.

// File: rtl/exu_imm_pkg.sv
package exu_imm_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDS = 3'd1,
    OP_SUB  = 3'd2,
    OP_SUBS = 3'd3,
    OP_MOVN = 3'd4,
    OP_MOVZ = 3'd5,
    OP_MOVK = 3'd6,
    OP_RSVD = 3'd7
  } exu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

endpackage

// File: rtl/exu_imm_arith.sv
module exu_imm_arith
  import exu_imm_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int NLEN      = 32,
  parameter int IMM_W     = 12,
  parameter int IMM_SHIFT = 12
) (
  input  logic            is_sub,
  input  logic            wide,
  input  logic [XLEN-1:0] src_val,
  input  logic [IMM_W-1:0] imm,
  input  logic            imm_sh,
  output logic [XLEN-1:0] sum,
  output nzcv_t           flags
);

  localparam int PAD_W = XLEN - IMM_W;

  function automatic logic [XLEN-1:0] fit(input logic [XLEN-1:0] x, input logic w);
    return w ? x : {{(XLEN-NLEN){1'b0}}, x[NLEN-1:0]};
  endfunction

  function automatic logic top_bit(input logic [XLEN-1:0] x, input logic w);
    return w ? x[XLEN-1] : x[NLEN-1];
  endfunction

  logic [XLEN-1:0] op_a;
  logic [XLEN-1:0] op_b;
  logic [XLEN-1:0] op_b_eff;
  logic [XLEN-1:0] imm_ext;
  logic [XLEN:0]   raw;
  logic            carry_out;
  logic            sa, sb, sr;

  always_comb begin
    imm_ext   = {{PAD_W{1'b0}}, imm};
    op_a      = fit(src_val, wide);
    op_b      = fit(imm_sh ? (imm_ext << IMM_SHIFT) : imm_ext, wide);
    op_b_eff  = fit(is_sub ? ~op_b : op_b, wide);
    raw       = {1'b0, op_a} + {1'b0, op_b_eff} + {{XLEN{1'b0}}, is_sub};
    sum       = fit(raw[XLEN-1:0], wide);
    carry_out = wide ? raw[XLEN] : raw[NLEN];
    sa        = top_bit(op_a, wide);
    sb        = top_bit(op_b, wide);
    sr        = top_bit(sum, wide);
    flags.n   = sr;
    flags.z   = (sum == '0);
    flags.c   = carry_out;
    flags.v   = is_sub ? ((sa != sb) && (sr == sb)) : ((sa == sb) && (sr != sa));
  end

  // R5: the carry out of a + ~b + 1 must agree with an unsigned compare
  always_comb begin
    if (is_sub) begin
      assert_sub_carry_R5: assert (flags.c == (op_a >= op_b));
    end
  end

  // R6: an add carries exactly when the truncated sum wrapped below a
  always_comb begin
    if (!is_sub) begin
      assert_add_carry_R6: assert (flags.c == (sum < op_a));
    end
  end

endmodule

// File: rtl/exu_imm_widemov.sv
module exu_imm_widemov
  import exu_imm_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NLEN  = 32,
  parameter int FLD_W = 16
) (
  input  exu_op_e             op,
  input  logic                wide,
  input  logic [XLEN-1:0]     dst_cur,
  input  logic [FLD_W-1:0]    mov_imm,
  input  logic [$clog2(XLEN/FLD_W)-1:0] fsel,
  output logic [XLEN-1:0]     mov_res,
  output logic                field_bad
);

  localparam int NFLD   = XLEN / FLD_W;
  localparam int NFLD_N = NLEN / FLD_W;
  localparam int SEL_W  = $clog2(NFLD);

  function automatic logic [XLEN-1:0] fit(input logic [XLEN-1:0] x, input logic w);
    return w ? x : {{(XLEN-NLEN){1'b0}}, x[NLEN-1:0]};
  endfunction

  function automatic logic [XLEN-1:0] place(input logic [FLD_W-1:0] v,
                                             input logic [SEL_W-1:0] s);
    logic [XLEN-1:0] ext;
    ext = {{(XLEN-FLD_W){1'b0}}, v};
    return ext << (32'(s) * FLD_W);
  endfunction

  logic [NFLD-1:0] hit;
  logic [XLEN-1:0] keep_mask;
  logic [XLEN-1:0] placed;
  logic [XLEN-1:0] width_mask;

  for (genvar i = 0; i < NFLD; i++) begin : g_lane
    assign hit[i] = (fsel == SEL_W'(i));
    assign keep_mask[i*FLD_W +: FLD_W] = hit[i] ? {FLD_W{1'b0}} : {FLD_W{1'b1}};
  end

  always_comb begin
    placed     = place(mov_imm, fsel);
    width_mask = fit({XLEN{1'b1}}, wide);
    field_bad  = !wide && (32'(fsel) >= NFLD_N);
    case (op)
      OP_MOVN: mov_res = fit(~placed, wide);
      OP_MOVZ: mov_res = fit(placed, wide);
      OP_MOVK: mov_res = fit((dst_cur & keep_mask) | placed, wide);
      default: mov_res = '0;
    endcase
  end

  // R8: exactly one lane is addressed and the shifted immediate sits only there
  always_comb begin
    assert_one_lane_R8: assert ($onehot0(hit) && ((placed & keep_mask) == '0));
  end

  // R9: a keep-move changes no bit outside the addressed lane
  always_comb begin
    if (op == OP_MOVK) begin
      assert_movk_keeps_R9: assert (((mov_res ^ dst_cur) & keep_mask & width_mask) == '0);
    end
  end

endmodule

// File: rtl/exu_imm_exec.sv
module exu_imm_exec
  import exu_imm_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int NLEN      = 32,
  parameter int IMM_W     = 12,
  parameter int IMM_SHIFT = 12,
  parameter int FLD_W     = 16
) (
  input  logic [2:0]       op_sel,
  input  logic             wide_mode,
  input  logic [XLEN-1:0]  src_val,
  input  logic [XLEN-1:0]  dst_cur,
  input  logic [IMM_W-1:0] arith_imm,
  input  logic             arith_sh,
  input  logic [FLD_W-1:0] mov_imm,
  input  logic [$clog2(XLEN/FLD_W)-1:0] mov_field,
  input  logic [3:0]       flag_in,
  output logic [XLEN-1:0]  result,
  output logic             wr_en,
  output logic [3:0]       flag_out,
  output logic             illegal
);

  exu_op_e         op;
  logic            is_arith;
  logic            is_move;
  logic            is_sub;
  logic            sets_flags;
  logic [XLEN-1:0] arith_sum;
  nzcv_t           arith_flags;
  logic [XLEN-1:0] mov_res;
  logic            field_bad;

  always_comb begin
    op         = exu_op_e'(op_sel);
    is_arith   = (op == OP_ADD) || (op == OP_ADDS) || (op == OP_SUB) || (op == OP_SUBS);
    is_move    = (op == OP_MOVN) || (op == OP_MOVZ) || (op == OP_MOVK);
    is_sub     = (op == OP_SUB) || (op == OP_SUBS);
    sets_flags = (op == OP_ADDS) || (op == OP_SUBS);
  end

  exu_imm_arith #(
    .XLEN(XLEN), .NLEN(NLEN), .IMM_W(IMM_W), .IMM_SHIFT(IMM_SHIFT)
  ) u_arith (
    .is_sub  (is_sub),
    .wide    (wide_mode),
    .src_val (src_val),
    .imm     (arith_imm),
    .imm_sh  (arith_sh),
    .sum     (arith_sum),
    .flags   (arith_flags)
  );

  exu_imm_widemov #(
    .XLEN(XLEN), .NLEN(NLEN), .FLD_W(FLD_W)
  ) u_wmov (
    .op        (op),
    .wide      (wide_mode),
    .dst_cur   (dst_cur),
    .mov_imm   (mov_imm),
    .fsel      (mov_field),
    .mov_res   (mov_res),
    .field_bad (field_bad)
  );

  always_comb begin
    illegal  = (!is_arith && !is_move) || (is_move && field_bad);
    wr_en    = !illegal;
    if (illegal)       result = '0;
    else if (is_arith) result = arith_sum;
    else               result = mov_res;
    flag_out = sets_flags ? arith_flags : flag_in;
  end

  // R10 / R11: a refused operation neither writes nor leaks a value
  always_comb begin
    if (illegal) begin
      assert_refused_quiet_R10: assert (!wr_en && (result == '0) && (flag_out == flag_in));
    end
  end

  // R7: narrow operation leaves the upper half clear
  always_comb begin
    if (!wide_mode) begin
      assert_narrow_upper_R7: assert (result[XLEN-1:NLEN] == '0);
    end
  end

  // R4: the zero flag follows the value actually written back
  always_comb begin
    if (sets_flags) begin
      assert_zero_flag_R4: assert (flag_out[2] == (result == '0));
    end
  end

endmodule

// File: tb/sim_exu_imm_exec.sv
`timescale 1ns/1ps
module sim_exu_imm_exec;

  typedef struct packed {
    logic [31:0] tag;
    logic [2:0]  op;
    logic        w;
    logic [63:0] src;
    logic [63:0] dst;
    logic [11:0] imm;
    logic        sh;
    logic [15:0] mimm;
    logic [1:0]  fld;
    logic [3:0]  fin;
    logic [63:0] eres;
    logic        ewe;
    logic [3:0]  ef;
    logic        eill;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VT [NV] = '{
    '{"R1",  3'd0, 1'b1, 64'h1000, 64'h0, 12'h123, 1'b1, 16'h0, 2'd0, 4'hA, 64'h124000, 1'b1, 4'hA, 1'b0},
    '{"R7",  3'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 12'h001, 1'b0, 16'h0, 2'd0, 4'h0, 64'h0, 1'b1, 4'h0, 1'b0},
    '{"R6",  3'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 12'h001, 1'b0, 16'h0, 2'd0, 4'h0, 64'h0, 1'b1, 4'h6, 1'b0},
    '{"R6",  3'd1, 1'b0, 64'h7FFF_FFFF, 64'h0, 12'h001, 1'b0, 16'h0, 2'd0, 4'h0, 64'h8000_0000, 1'b1, 4'h9, 1'b0},
    '{"R6",  3'd1, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 12'hFFF, 1'b1, 16'h0, 2'd0, 4'h0, 64'h8000_0000_00FF_EFFF, 1'b1, 4'h9, 1'b0},
    '{"R4",  3'd3, 1'b1, 64'h5, 64'h0, 12'h005, 1'b0, 16'h0, 2'd0, 4'h0, 64'h0, 1'b1, 4'h6, 1'b0},
    '{"R5",  3'd3, 1'b1, 64'h3, 64'h0, 12'h005, 1'b0, 16'h0, 2'd0, 4'h0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1, 4'h8, 1'b0},
    '{"R5",  3'd3, 1'b0, 64'h8000_0000, 64'h0, 12'h001, 1'b0, 16'h0, 2'd0, 4'h0, 64'h7FFF_FFFF, 1'b1, 4'h3, 1'b0},
    '{"R3",  3'd2, 1'b0, 64'hDEAD_BEEF_0000_0010, 64'h0, 12'h001, 1'b1, 16'h0, 2'd0, 4'hF, 64'h0000_0000_FFFF_F010, 1'b1, 4'hF, 1'b0},
    '{"R8",  3'd5, 1'b1, 64'h0, 64'h0, 12'h0, 1'b0, 16'hBEEF, 2'd2, 4'h5, 64'h0000_BEEF_0000_0000, 1'b1, 4'h5, 1'b0},
    '{"R8",  3'd4, 1'b1, 64'h0, 64'h0, 12'h0, 1'b0, 16'h1234, 2'd1, 4'h0, 64'hFFFF_FFFF_EDCB_FFFF, 1'b1, 4'h0, 1'b0},
    '{"R8",  3'd4, 1'b0, 64'h0, 64'h0, 12'h0, 1'b0, 16'h00FF, 2'd0, 4'h0, 64'h0000_0000_FFFF_FF00, 1'b1, 4'h0, 1'b0},
    '{"R9",  3'd6, 1'b1, 64'h0, 64'h1111_2222_3333_4444, 12'h0, 1'b0, 16'hABCD, 2'd3, 4'h0, 64'hABCD_2222_3333_4444, 1'b1, 4'h0, 1'b0},
    '{"R9",  3'd6, 1'b0, 64'h0, 64'h9999_8888_7777_6666, 12'h0, 1'b0, 16'h5555, 2'd1, 4'h0, 64'h0000_0000_5555_6666, 1'b1, 4'h0, 1'b0},
    '{"R10", 3'd5, 1'b0, 64'h0, 64'h0, 12'h0, 1'b0, 16'h1234, 2'd2, 4'hC, 64'h0, 1'b0, 4'hC, 1'b1},
    '{"R11", 3'd7, 1'b1, 64'h55, 64'h66, 12'h007, 1'b1, 16'h9, 2'd0, 4'h3, 64'h0, 1'b0, 4'h3, 1'b1},
    '{"R10", 3'd6, 1'b0, 64'h0, 64'hFFFF, 12'h0, 1'b0, 16'h1, 2'd3, 4'h0, 64'h0, 1'b0, 4'h0, 1'b1},
    '{"R2",  3'd3, 1'b0, 64'h2000, 64'h0, 12'h002, 1'b1, 16'h0, 2'd0, 4'h0, 64'h0, 1'b1, 4'h6, 1'b0}
  };

  logic        clk = 1'b0;
  logic [2:0]  op_sel;
  logic        wide_mode;
  logic [63:0] src_val, dst_cur, result;
  logic [11:0] arith_imm;
  logic        arith_sh;
  logic [15:0] mov_imm;
  logic [1:0]  mov_field;
  logic [3:0]  flag_in, flag_out;
  logic        wr_en, illegal;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  exu_imm_exec u0 (
    .op_sel(op_sel), .wide_mode(wide_mode), .src_val(src_val), .dst_cur(dst_cur),
    .arith_imm(arith_imm), .arith_sh(arith_sh), .mov_imm(mov_imm), .mov_field(mov_field),
    .flag_in(flag_in), .result(result), .wr_en(wr_en), .flag_out(flag_out), .illegal(illegal)
  );

  task automatic check64(input logic [31:0] tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    op_sel    = v.op;
    wide_mode = v.w;
    src_val   = v.src;
    dst_cur   = v.dst;
    arith_imm = v.imm;
    arith_sh  = v.sh;
    mov_imm   = v.mimm;
    mov_field = v.fld;
    flag_in   = v.fin;
    @(posedge clk);
    #1;
    check64(v.tag, "result",  result, v.eres);
    check64(v.tag, "wr_en",   {63'b0, wr_en}, {63'b0, v.ewe});
    check64(v.tag, "flags",   {60'b0, flag_out}, {60'b0, v.ef});
    check64(v.tag, "illegal", {63'b0, illegal}, {63'b0, v.eill});
  endtask

  initial begin
    // R1: all-zero inputs decode to ADD, write zero, keep flags
    run_vec('{"R1", 3'd0, 1'b1, 64'h0, 64'h0, 12'h0, 1'b0, 16'h0, 2'd0, 4'h0, 64'h0, 1'b1, 4'h0, 1'b0});
    for (int i = 0; i < NV; i++) begin
      run_vec(VT[i]);
    end
    // R6: 64-bit carry out with zero result
    run_vec('{"R6", 3'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 12'h001, 1'b0, 16'h0, 2'd0, 4'h0, 64'h0, 1'b1, 4'h6, 1'b0});
    // R4: all-ones sum, negative without carry
    run_vec('{"R4", 3'd1, 1'b1, 64'hFFFF_FFFF_FFFF_F000, 64'h0, 12'hFFF, 1'b0, 16'h0, 2'd0, 4'hF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 4'h8, 1'b0});
    // R7: MOVZ at 32 bits, lane 1, ignores upper destination bits
    run_vec('{"R7", 3'd5, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 12'h0, 1'b0, 16'hC0DE, 2'd1, 4'h0, 64'h0000_0000_C0DE_0000, 1'b1, 4'h0, 1'b0});
    // R9: MOVK lane 0 at 64 bits
    run_vec('{"R9", 3'd6, 1'b1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 12'h0, 1'b0, 16'h0000, 2'd0, 4'h7, 64'hFFFF_FFFF_FFFF_0000, 1'b1, 4'h7, 1'b0});
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=5000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule